// File: doc/BRIEF.md
# DMA Channel Register File

This block is the host-side register file of a four-channel DMA controller. A host with an 8-bit I/O path programs a 16-bit start address and a 16-bit transfer count for each channel. It also sets per-channel mode, per-channel mask bits and a global command byte. A transfer engine next to the block reads those values and reports progress back. Each register port is one byte wide, so every 16-bit value takes two accesses to the same port. A single byte-pointer flag, shared by all channels, chooses between the low byte and the high byte. Each access flips that flag. Software sets it back to the low-byte state by writing the clear-pointer port.

For every channel the block keeps a base copy and a current copy of the address and the count. A host write to an address or count port updates the addressed byte of both copies. The engine can overwrite the current copy at any time. When the engine reports terminal count on a channel whose mode selects auto-initialise, the block reloads the current copy from the base copy. Host reads of the channel ports return the current copy. The count holds the number of transfers minus one, so 0x0000 means one transfer and 0xFFFF means 65536. The block only stores the count; it does not interpret it.

The I/O map has sixteen byte offsets. Channel n has its address port at offset 2n and its count port at offset 2n+1. The control ports are at offsets 8 to 15: command write / status read (8), request (9, no effect), single-channel mask (10), mode (11), clear pointer (12), master clear write / temporary read (13), clear all masks (14) and write all masks (15).

Top module: `dma_io_regfile`

## Requirements
- R1: After reset all four mask bits are 1, the command byte is 0x00, every mode field is 0, every address and count is 0x0000, the status byte reads as eng_req in bits 7:4 over zeros, and the byte pointer selects the low byte.
- R2: A write to offset 2n (address) or 2n+1 (count) stores the data byte into the low byte of channel n's value when the pointer is low, and into the high byte when it is high. The same byte is written in both the base copy and the current copy.
- R3: A read of offset 2n or 2n+1 returns the low or high byte of channel n's current address or count, as the pointer selects. Every read or write of offsets 0 to 7 flips the pointer.
- R4: A write of any value to offset 12 sets the pointer to the low-byte state.
- R5: A write to offset 10 uses data bits 1:0 as the channel number. Data bit 2 = 1 sets that channel's mask bit and bit 2 = 0 clears it. The other mask bits do not change.
- R6: A write to offset 15 loads data bits 3:0 into the four mask bits (bit n for channel n). A write of any value to offset 14 clears all four mask bits.
- R7: A write to offset 11 uses data bits 1:0 as the channel number and stores data bits 7:2 as that channel's 6-bit mode field. Other channels' mode fields do not change. Mode byte bit 4 (field bit 2) is the auto-initialise enable.
- R8: A write to offset 8 loads the command byte. A read of offset 8 returns status: bits 3:0 are per-channel terminal-count flags, set by an eng_tc pulse and held; bits 7:4 show eng_req as it is at that moment. The read clears the terminal-count flags, but a pulse in the same cycle still sets its flag.
- R9: A write of any value to offset 13 sets all mask bits, clears the command byte and the terminal-count flags, and resets the pointer. It leaves addresses, counts and mode fields unchanged. A read of offset 13 returns 0x00.
- R10: An eng_ld pulse on channel n loads eng_nxt_addr and eng_nxt_cnt into that channel's current copies. The base copies do not change.
- R11: An eng_tc pulse on a channel whose auto-initialise bit is set copies base address and base count into the current copies. With the bit clear, the current copies are kept.
- R12: If a host byte write and an eng_ld pulse hit the same channel value in one cycle, the host byte takes that byte position. The engine value fills the other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 4 | Host byte offset |
| io_wdata | input | 8 | Host write byte |
| io_wr | input | 1 | Host write strobe, one cycle per byte |
| io_rd | input | 1 | Host read strobe, one cycle per byte |
| io_rdata | output | 8 | Read byte, valid in the cycle io_rd is high, 0 otherwise |
| eng_ld | input | 4 | Per-channel load of the current copies from the engine |
| eng_nxt_addr | input | 64 | Engine next addresses, channel n at bits 16n+15:16n |
| eng_nxt_cnt | input | 64 | Engine next counts, same packing |
| eng_tc | input | 4 | Per-channel terminal-count pulse |
| eng_req | input | 4 | Live per-channel request lines shown in status |
| eng_mask | output | 4 | Mask bit per channel |
| eng_mode | output | 24 | Mode fields, channel n at bits 6n+5:6n |
| eng_cmd | output | 8 | Command byte |
| eng_base_addr | output | 64 | Base addresses, 16 bits per channel |
| eng_base_cnt | output | 64 | Base counts, 16 bits per channel |
| eng_cur_addr | output | 64 | Current addresses, 16 bits per channel |
| eng_cur_cnt | output | 64 | Current counts, 16 bits per channel |

## Verification
The checker assumes the host never raises io_wr and io_rd in the same cycle. It flags any cycle where both are high, because then the pointer step and the byte selection would be ambiguous. The pointer and base-copy properties also assume that eng_ld does not coincide with a host write when base stability is checked. The directed tasks drive one host strobe at a time with idle cycles between accesses. They raise engine pulses alone, except in the collision scenario written for R12.

// File: rtl/dmarf_pkg.sv
// Package: dmarf_pkg
// Shared sizes and I/O offsets for the DMA channel register file.
// Assumes an 8-bit host path and 16-bit channel values (two bytes each).
package dmarf_pkg;
    localparam int NCH       = 4;
    localparam int BYTE_W    = 8;
    localparam int REG_W     = 2 * BYTE_W;
    localparam int MODE_W    = 6;
    localparam int ADDR_W    = 4;
    localparam int CH_W      = $clog2(NCH);
    localparam int CHAN_PORTS = 2 * NCH;
    // Position of the auto-initialise enable inside the stored mode field
    localparam int AUTO_BIT  = 4 - (BYTE_W - MODE_W);
    // Data bit that carries the set/clear flag of a single-channel mask write
    localparam int MASK_VAL_BIT = 2;

    localparam logic [ADDR_W-1:0] OFS_CMD_STAT = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_REQUEST  = 4'h9;
    localparam logic [ADDR_W-1:0] OFS_MASK_ONE = 4'hA;
    localparam logic [ADDR_W-1:0] OFS_MODE     = 4'hB;
    localparam logic [ADDR_W-1:0] OFS_PTR_CLR  = 4'hC;
    localparam logic [ADDR_W-1:0] OFS_MCLR_TMP = 4'hD;
    localparam logic [ADDR_W-1:0] OFS_MASK_CLR = 4'hE;
    localparam logic [ADDR_W-1:0] OFS_MASK_ALL = 4'hF;
endpackage

// File: rtl/dma_byte_ptr.sv
// Module: dma_byte_ptr
// The shared byte-pointer flag: 0 selects the low byte, 1 the high byte.
// Assumes step and clear are single-cycle strobes; clear wins over step.
module dma_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clear,
    output logic hi
);
    // Flip on each channel-port access, return to low on clear or reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi <= 1'b0;
        end else if (clear) begin
            hi <= 1'b0;
        end else if (step) begin
            hi <= ~hi;
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
// Module: dma_chan_regs
// Base and current address/count of one channel.
// Assumes REG_W is exactly two host bytes. Priority on the current copy:
// auto-init reload over engine load, then the host byte over both.
module dma_chan_regs #(
    parameter int BYTE_W = 8,
    parameter int REG_W  = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              hi_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              eng_ld,
    input  logic [REG_W-1:0]  nxt_addr,
    input  logic [REG_W-1:0]  nxt_cnt,
    input  logic              reload,
    output logic [REG_W-1:0]  base_addr,
    output logic [REG_W-1:0]  base_cnt,
    output logic [REG_W-1:0]  cur_addr,
    output logic [REG_W-1:0]  cur_cnt
);
    logic [REG_W-1:0] base_addr_d, base_cnt_d, cur_addr_d, cur_cnt_d;

    // Put one host byte into a 16-bit value at the position the pointer picks
    function automatic logic [REG_W-1:0] put_byte(input logic [REG_W-1:0] v,
                                                  input logic hi,
                                                  input logic [BYTE_W-1:0] b);
        logic [REG_W-1:0] r;
        r = v;
        if (hi) r[REG_W-1:BYTE_W] = b;
        else    r[BYTE_W-1:0]     = b;
        return r;
    endfunction

    // Next-state of all four values from reload, engine load and host byte
    always_comb begin
        base_addr_d = base_addr;
        base_cnt_d  = base_cnt;
        cur_addr_d  = cur_addr;
        cur_cnt_d   = cur_cnt;
        if (reload) begin
            cur_addr_d = base_addr;
            cur_cnt_d  = base_cnt;
        end else if (eng_ld) begin
            cur_addr_d = nxt_addr;
            cur_cnt_d  = nxt_cnt;
        end
        if (wr_addr) begin
            base_addr_d = put_byte(base_addr, hi_sel, wdata);
            cur_addr_d  = put_byte(cur_addr_d, hi_sel, wdata);
        end
        if (wr_cnt) begin
            base_cnt_d = put_byte(base_cnt, hi_sel, wdata);
            cur_cnt_d  = put_byte(cur_cnt_d, hi_sel, wdata);
        end
    end

    // Register the channel values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
        end else begin
            base_addr <= base_addr_d;
            base_cnt  <= base_cnt_d;
            cur_addr  <= cur_addr_d;
            cur_cnt   <= cur_cnt_d;
        end
    end
endmodule

// File: rtl/dma_ctrl_regs.sv
// Module: dma_ctrl_regs
// Mask bits, per-channel mode fields, command byte and terminal-count flags.
// Assumes the write strobes arrive already decoded and at most one per cycle.
module dma_ctrl_regs #(
    parameter int NCH    = 4,
    parameter int BYTE_W = 8,
    parameter int MODE_W = 6,
    parameter int CH_W   = 2,
    parameter int MASK_VAL_BIT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BYTE_W-1:0]     wdata,
    input  logic                  wr_cmd,
    input  logic                  wr_mask_one,
    input  logic                  wr_mask_all,
    input  logic                  wr_mask_clr,
    input  logic                  wr_mode,
    input  logic                  mclr,
    input  logic                  rd_status,
    input  logic [NCH-1:0]        eng_tc,
    input  logic [NCH-1:0]        eng_req,
    output logic [NCH-1:0]        mask,
    output logic [NCH*MODE_W-1:0] mode,
    output logic [BYTE_W-1:0]     cmd,
    output logic [BYTE_W-1:0]     status
);
    logic [NCH-1:0] tc_flag;

    // Mask bits: master clear and reset mask all, then the three host ports
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            mask <= '1;
        end else if (wr_mask_clr) begin
            mask <= '0;
        end else if (wr_mask_all) begin
            mask <= wdata[NCH-1:0];
        end else if (wr_mask_one) begin
            mask[wdata[CH_W-1:0]] <= wdata[MASK_VAL_BIT];
        end
    end

    // Mode fields, one per channel, kept across master clear
    for (genvar c = 0; c < NCH; c++) begin : g_mode
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode[c*MODE_W +: MODE_W] <= '0;
            end else if (wr_mode && wdata[CH_W-1:0] == CH_W'(c)) begin
                mode[c*MODE_W +: MODE_W] <= wdata[BYTE_W-1:BYTE_W-MODE_W];
            end
        end
    end

    // Command byte, cleared by master clear
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            cmd <= '0;
        end else if (wr_cmd) begin
            cmd <= wdata;
        end
    end

    // Sticky terminal-count flags: a status read clears, a new pulse still sets
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            tc_flag <= '0;
        end else begin
            tc_flag <= (rd_status ? '0 : tc_flag) | eng_tc;
        end
    end

    // Status byte: live requests over held terminal-count flags
    assign status = {eng_req, tc_flag};
endmodule

// File: rtl/dma_io_regfile.sv
// Module: dma_io_regfile
// Top of the DMA channel register file. It decodes the 16-byte host map,
// steers bytes through the shared pointer and muxes read data.
// Assumes io_wr and io_rd are never high together; io_rdata is combinational.
module dma_io_regfile
    import dmarf_pkg::*;
#(
    parameter int NUM_CH = NCH,
    parameter int VAL_W  = REG_W,
    parameter int MODE_BITS = MODE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         io_addr,
    input  logic [BYTE_W-1:0]         io_wdata,
    input  logic                      io_wr,
    input  logic                      io_rd,
    output logic [BYTE_W-1:0]         io_rdata,
    input  logic [NUM_CH-1:0]         eng_ld,
    input  logic [NUM_CH*VAL_W-1:0]   eng_nxt_addr,
    input  logic [NUM_CH*VAL_W-1:0]   eng_nxt_cnt,
    input  logic [NUM_CH-1:0]         eng_tc,
    input  logic [NUM_CH-1:0]         eng_req,
    output logic [NUM_CH-1:0]         eng_mask,
    output logic [NUM_CH*MODE_BITS-1:0] eng_mode,
    output logic [BYTE_W-1:0]         eng_cmd,
    output logic [NUM_CH*VAL_W-1:0]   eng_base_addr,
    output logic [NUM_CH*VAL_W-1:0]   eng_base_cnt,
    output logic [NUM_CH*VAL_W-1:0]   eng_cur_addr,
    output logic [NUM_CH*VAL_W-1:0]   eng_cur_cnt
);
    localparam int SEL_W = $clog2(NUM_CH);

    logic              chan_hit;
    logic [SEL_W-1:0]  sel_ch;
    logic              sel_cnt;
    logic              ptr_hi;
    logic              ptr_step;
    logic              ptr_clr;
    logic              mclr;
    logic              rd_status;
    logic [BYTE_W-1:0] status;
    logic [VAL_W-1:0]  cur_addr_a [NUM_CH];
    logic [VAL_W-1:0]  cur_cnt_a  [NUM_CH];
    logic [VAL_W-1:0]  rd_val;

    // Address decode of channel ports and control strobes
    assign chan_hit  = (io_addr < ADDR_W'(CHAN_PORTS));
    assign sel_ch    = io_addr[SEL_W:1];
    assign sel_cnt   = io_addr[0];
    assign ptr_step  = (io_wr || io_rd) && chan_hit;
    assign ptr_clr   = io_wr && (io_addr == OFS_PTR_CLR);
    assign mclr      = io_wr && (io_addr == OFS_MCLR_TMP);
    assign rd_status = io_rd && (io_addr == OFS_CMD_STAT);

    dma_byte_ptr u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ptr_step),
        .clear (ptr_clr || mclr),
        .hi    (ptr_hi)
    );

    dma_ctrl_regs #(
        .NCH          (NUM_CH),
        .BYTE_W       (BYTE_W),
        .MODE_W       (MODE_BITS),
        .CH_W         (SEL_W),
        .MASK_VAL_BIT (MASK_VAL_BIT)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wdata       (io_wdata),
        .wr_cmd      (io_wr && io_addr == OFS_CMD_STAT),
        .wr_mask_one (io_wr && io_addr == OFS_MASK_ONE),
        .wr_mask_all (io_wr && io_addr == OFS_MASK_ALL),
        .wr_mask_clr (io_wr && io_addr == OFS_MASK_CLR),
        .wr_mode     (io_wr && io_addr == OFS_MODE),
        .mclr        (mclr),
        .rd_status   (rd_status),
        .eng_tc      (eng_tc),
        .eng_req     (eng_req),
        .mask        (eng_mask),
        .mode        (eng_mode),
        .cmd         (eng_cmd),
        .status      (status)
    );

    // One register set per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit_c;
        assign hit_c = io_wr && chan_hit && (sel_ch == SEL_W'(c));

        dma_chan_regs #(
            .BYTE_W (BYTE_W),
            .REG_W  (VAL_W)
        ) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_addr   (hit_c && !sel_cnt),
            .wr_cnt    (hit_c && sel_cnt),
            .hi_sel    (ptr_hi),
            .wdata     (io_wdata),
            .eng_ld    (eng_ld[c]),
            .nxt_addr  (eng_nxt_addr[c*VAL_W +: VAL_W]),
            .nxt_cnt   (eng_nxt_cnt[c*VAL_W +: VAL_W]),
            .reload    (eng_tc[c] && eng_mode[c*MODE_BITS + AUTO_BIT]),
            .base_addr (eng_base_addr[c*VAL_W +: VAL_W]),
            .base_cnt  (eng_base_cnt[c*VAL_W +: VAL_W]),
            .cur_addr  (eng_cur_addr[c*VAL_W +: VAL_W]),
            .cur_cnt   (eng_cur_cnt[c*VAL_W +: VAL_W])
        );

        assign cur_addr_a[c] = eng_cur_addr[c*VAL_W +: VAL_W];
        assign cur_cnt_a[c]  = eng_cur_cnt[c*VAL_W +: VAL_W];
    end

    // Current value of the addressed channel port
    assign rd_val = sel_cnt ? cur_cnt_a[sel_ch] : cur_addr_a[sel_ch];

    // Read data mux: channel byte by pointer, status, or zero
    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (chan_hit) begin
                io_rdata = ptr_hi ? rd_val[VAL_W-1:BYTE_W] : rd_val[BYTE_W-1:0];
            end else if (io_addr == OFS_CMD_STAT) begin
                io_rdata = status;
            end
        end
    end
endmodule

// File: rtl/dma_io_regfile_chk.sv
// Module: dma_io_regfile_chk
// Property checker bound into dma_io_regfile.
// Assumes the host never issues a read and a write in the same cycle.
module dma_io_regfile_chk
    import dmarf_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    io_addr,
    input logic [BYTE_W-1:0]    io_wdata,
    input logic                 io_wr,
    input logic                 io_rd,
    input logic                 ptr_hi,
    input logic [NCH-1:0]       eng_ld,
    input logic [NCH-1:0]       eng_mask,
    input logic [NCH*MODE_W-1:0] eng_mode,
    input logic [BYTE_W-1:0]    eng_cmd,
    input logic [NCH*REG_W-1:0] eng_base_addr
);
    a_in_wr_rd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_rd));

    // R3: each channel-port access flips the pointer
    a_r3_ptr_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr || io_rd) && io_addr < ADDR_W'(CHAN_PORTS) |=> ptr_hi != $past(ptr_hi));

    // R4: clear-pointer write leaves the pointer low
    a_r4_ptr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && io_addr == OFS_PTR_CLR |=> !ptr_hi);

    // R5: single-channel mask write sets the selected bit to data bit 2
    a_r5_single_mask: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && io_addr == OFS_MASK_ONE |=>
        eng_mask[$past(io_wdata[CH_W-1:0])] == $past(io_wdata[MASK_VAL_BIT]));

    // R6: clear-mask port unmasks every channel
    a_r6_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && io_addr == OFS_MASK_CLR |=> eng_mask == '0);

    // R7: mode write lands in the selected channel's field
    a_r7_mode_stored: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && io_addr == OFS_MODE |=>
        eng_mode[$past(io_wdata[CH_W-1:0])*MODE_W +: MODE_W] == $past(io_wdata[BYTE_W-1:BYTE_W-MODE_W]));

    // R8: command write is held in the command byte
    a_r8_cmd_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && io_addr == OFS_CMD_STAT |=> eng_cmd == $past(io_wdata));

    // R9: master clear masks all, clears command, resets pointer
    a_r9_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && io_addr == OFS_MCLR_TMP |=> eng_mask == '1 && eng_cmd == '0 && !ptr_hi);

    // R10: an engine load alone never disturbs the base addresses
    a_r10_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
        eng_ld != '0 && !io_wr |=> $stable(eng_base_addr));
endmodule

bind dma_io_regfile dma_io_regfile_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_addr       (io_addr),
    .io_wdata      (io_wdata),
    .io_wr         (io_wr),
    .io_rd         (io_rd),
    .ptr_hi        (ptr_hi),
    .eng_ld        (eng_ld),
    .eng_mask      (eng_mask),
    .eng_mode      (eng_mode),
    .eng_cmd       (eng_cmd),
    .eng_base_addr (eng_base_addr)
);

// File: tb/test_dma_io_regfile.sv
// Directed bench for dma_io_regfile: one task per scenario, each self-checking.
module test_dma_io_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic [3:0]  eng_ld = '0;
    logic [63:0] eng_nxt_addr = '0;
    logic [63:0] eng_nxt_cnt = '0;
    logic [3:0]  eng_tc = '0;
    logic [3:0]  eng_req = '0;
    logic [3:0]  eng_mask;
    logic [23:0] eng_mode;
    logic [7:0]  eng_cmd;
    logic [63:0] eng_base_addr, eng_base_cnt, eng_cur_addr, eng_cur_cnt;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    dma_io_regfile i_dma_io_regfile (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .eng_ld(eng_ld),
        .eng_nxt_addr(eng_nxt_addr), .eng_nxt_cnt(eng_nxt_cnt), .eng_tc(eng_tc),
        .eng_req(eng_req), .eng_mask(eng_mask), .eng_mode(eng_mode),
        .eng_cmd(eng_cmd), .eng_base_addr(eng_base_addr), .eng_base_cnt(eng_base_cnt),
        .eng_cur_addr(eng_cur_addr), .eng_cur_cnt(eng_cur_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] w16(input logic [63:0] v, input int ch);
        return v[ch*16 +: 16];
    endfunction

    function automatic logic [5:0] md(input int ch);
        return eng_mode[ch*6 +: 6];
    endfunction

    task automatic io_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk); io_rd = 1'b0;
    endtask

    task automatic eng_load(input int ch, input logic [15:0] a, input logic [15:0] c);
        @(negedge clk);
        eng_nxt_addr[ch*16 +: 16] = a; eng_nxt_cnt[ch*16 +: 16] = c; eng_ld[ch] = 1'b1;
        @(negedge clk); eng_ld = '0;
    endtask

    task automatic eng_term(input logic [3:0] m);
        @(negedge clk); eng_tc = m;
        @(negedge clk); eng_tc = '0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 mask", eng_mask, 4'hF);
        chk("R1 cmd", eng_cmd, 8'h00);
        chk("R1 mode", eng_mode, 24'h0);
        chk("R1 cur addr", eng_cur_addr[31:0], 32'h0);
        eng_req = 4'h9;
        io_read(4'h8, d);
        chk("R1 status", d, 8'h90);
        eng_req = 4'h0;
        io_read(4'h0, d);
        io_read(4'h0, d);
        chk("R1 ptr back low", d, 8'h00);
    endtask

    task automatic t_program;
        io_write(4'hC, 8'h00);
        for (int c = 0; c < 4; c++) begin
            logic [15:0] a, n;
            a = 16'h1234 + 16'(c) * 16'h1111;
            n = 16'h00FF + 16'(c) * 16'h0101;
            io_write(4'(2*c), a[7:0]);   io_write(4'(2*c), a[15:8]);
            io_write(4'(2*c+1), n[7:0]); io_write(4'(2*c+1), n[15:8]);
        end
        for (int c = 0; c < 4; c++) begin
            chk("R2 base addr", w16(eng_base_addr, c), 16'h1234 + 16'(c) * 16'h1111);
            chk("R2 cur addr", w16(eng_cur_addr, c), 16'h1234 + 16'(c) * 16'h1111);
            chk("R2 base cnt", w16(eng_base_cnt, c), 16'h00FF + 16'(c) * 16'h0101);
            chk("R2 cur cnt", w16(eng_cur_cnt, c), 16'h00FF + 16'(c) * 16'h0101);
        end
    endtask

    task automatic t_readback;
        logic [7:0] lo, hi;
        io_write(4'hC, 8'h00);
        io_read(4'h4, lo); io_read(4'h4, hi);
        chk("R3 ch2 addr", {hi, lo}, 16'h3456);
        io_read(4'h7, lo); io_read(4'h7, hi);
        chk("R3 ch3 count", {hi, lo}, 16'h0402);
    endtask

    task automatic t_ptr_clear;
        io_write(4'h0, 8'hAA);
        io_write(4'hC, 8'h5A);
        io_write(4'h0, 8'h55);
        chk("R4 low byte after clear", w16(eng_base_addr, 0), 16'h1255);
        io_write(4'hC, 8'h00);
    endtask

    task automatic t_mask;
        io_write(4'hA, 8'h01);
        chk("R5 unmask ch1", eng_mask, 4'hD);
        io_write(4'hA, 8'h06);
        chk("R5 mask ch2 kept", eng_mask, 4'hD);
        io_write(4'hA, 8'h03);
        chk("R5 unmask ch3", eng_mask, 4'h5);
        io_write(4'hF, 8'hFA);
        chk("R6 all mask", eng_mask, 4'hA);
        io_write(4'hE, 8'h33);
        chk("R6 clear mask", eng_mask, 4'h0);
    endtask

    task automatic t_mode;
        io_write(4'hB, 8'h46);
        io_write(4'hB, 8'h59);
        io_write(4'hB, 8'hC3);
        chk("R7 ch2 device-to-mem", md(2), 6'h11);
        chk("R7 ch1 autoinit", md(1), 6'h16);
        chk("R7 ch3 cascade", md(3), 6'h30);
        chk("R7 ch0 untouched", md(0), 6'h00);
    endtask

    task automatic t_status;
        logic [7:0] d;
        io_write(4'h8, 8'h0A);
        chk("R8 cmd", eng_cmd, 8'h0A);
        eng_term(4'b1001);
        eng_req = 4'b0110;
        io_read(4'h8, d);
        chk("R8 status", d, 8'h69);
        io_read(4'h8, d);
        chk("R8 cleared by read", d, 8'h60);
        eng_req = 4'h0;
    endtask

    task automatic t_engine_load;
        logic [7:0] d;
        eng_load(3, 16'hA5C3, 16'h0007);
        chk("R10 cur addr", w16(eng_cur_addr, 3), 16'hA5C3);
        chk("R10 cur cnt", w16(eng_cur_cnt, 3), 16'h0007);
        chk("R10 base kept", w16(eng_base_addr, 3), 16'h4567);
        io_read(4'h6, d);
        chk("R3 read current", d, 8'hC3);
        io_write(4'hC, 8'h00);
    endtask

    task automatic t_autoinit;
        eng_load(1, 16'h0000, 16'h0000);
        eng_term(4'b0010);
        chk("R11 reload addr", w16(eng_cur_addr, 1), 16'h2345);
        chk("R11 reload cnt", w16(eng_cur_cnt, 1), 16'h0200);
        eng_load(2, 16'h9999, 16'h0001);
        eng_term(4'b0100);
        chk("R11 no reload", w16(eng_cur_addr, 2), 16'h9999);
    endtask

    task automatic t_collision;
        @(negedge clk);
        eng_nxt_addr[15:0] = 16'hBEEF; eng_nxt_cnt[15:0] = 16'h0010; eng_ld[0] = 1'b1;
        io_addr = 4'h0; io_wdata = 8'h11; io_wr = 1'b1;
        @(negedge clk); eng_ld = '0; io_wr = 1'b0;
        chk("R12 host byte wins", w16(eng_cur_addr, 0), 16'hBE11);
        chk("R12 base byte", w16(eng_base_addr, 0), 16'h1211);
        chk("R12 cnt from engine", w16(eng_cur_cnt, 0), 16'h0010);
        io_write(4'hC, 8'h00);
    endtask

    task automatic t_master_clear;
        logic [7:0] d;
        io_write(4'h8, 8'hC4);
        io_write(4'hE, 8'h00);
        io_write(4'h0, 8'h77);
        io_write(4'hD, 8'h00);
        chk("R9 mask set", eng_mask, 4'hF);
        chk("R9 cmd clear", eng_cmd, 8'h00);
        io_write(4'h0, 8'h66);
        chk("R9 ptr reset", w16(eng_base_addr, 0), 16'h1266);
        io_write(4'hC, 8'h00);
        io_read(4'h8, d);
        chk("R9 status clear", d, 8'h00);
        io_read(4'hD, d);
        chk("R9 temp reads zero", d, 8'h00);
        chk("R9 mode kept", md(2), 6'h11);
        chk("R9 base kept", w16(eng_base_addr, 1), 16'h2345);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_readback();
        t_ptr_clear();
        t_mask();
        t_mode();
        t_status();
        t_engine_load();
        t_autoinit();
        t_collision();
        t_master_clear();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule